// File: doc/BRIEF.md
# Quad-SPI Flash Command Sequencer

This block runs one serial-flash transaction at a time over a four-line SPI bus in indirect mode. Software programs a 24-bit command word, an address and a byte count through a small register write port. The sequencer then drives chip select low and steps through up to four phases in a fixed order: instruction, address, dummy and data. Each of the instruction, address and data phases has its own line-width code. That code either skips the phase or runs it on one, two or four lines. Write data is pulled byte by byte from an external byte FIFO, and read data is pushed byte by byte into another one.

The serial clock runs at half the system clock. Data changes while the serial clock is low, and both the sequencer and the flash sample on the rising edge. Busy, transfer-complete, transfer-error and FIFO-threshold indications are brought out as ports. The two sticky flags are cleared by writing ones to a flag-clear register. A self-clearing abort bit stops any phase immediately.

Register select values: 0 control (bit 0 abort), 1 command word, 2 address, 3 byte count minus one, 4 flag clear (bit 0 complete, bit 1 error). Command word fields: [7:0] opcode, [9:8] instruction width, [11:10] address width, [13:12] address bytes minus one, [19:14] dummy cycles, [21:20] data width, [23:22] function (0 write, 1 read, 2 and 3 unsupported). Width codes: 0 skip, 1 one line, 2 two lines, 3 four lines.

Top module: `qspi_seq`

## Requirements
- R1: After reset, cs_n is high, sck is low, io_oe is 0, and busy, done_flag, err_flag, fifo_thr and abort_bit are all low.
- R2: The command word's address width field controls when a transaction starts. When it is non-zero, the transaction starts on the clock edge that takes an address write. When it is zero, the transaction starts on the edge that takes the command word write. In both cases busy is high at the next sample. Writes to select 1, 2 or 3 while busy have no effect.
- R3: The phases run in the order instruction, address, dummy, data. A width code of 0 skips its phase, and a dummy count of 0 skips the dummy phase.
- R4: Width code 1 drives io_out[0] and reads io_in[1]. Code 2 uses io[1:0]. Code 3 uses io[3:0]. Data goes most significant bit first, and the highest line carries the highest bit of each group. io_oe is 0001, 0011 or 1111 during instruction, address and write-data steps, and 0 otherwise.
- R5: The address phase sends (address-size field + 1) bytes, taken from the low bytes of the address register. The data phase moves (count register + 1) bytes.
- R6: The dummy phase lasts exactly the programmed number of serial clocks with all outputs released.
- R7: In a write, tx_pop takes one byte per data byte. While tx_valid is low at a byte boundary, sck stays low and fifo_thr is high.
- R8: In a read, each received byte is presented on rx_data with a one-cycle rx_push. While rx_full is high at a byte boundary, sck stays low.
- R9: done_flag rises on the edge that ends the last phase, and cs_n rises on that same edge. Writing bit 0 of the flag-clear register clears done_flag.
- R10: A start with function code 2 or 3 sets err_flag and runs no transaction. Writing bit 1 of the flag-clear register clears err_flag.
- R11: Writing 1 to the abort bit returns the block to idle on that edge, with cs_n high and done_flag unchanged. abort_bit reads high for one cycle and then clears itself.
- R12: Each serial step lasts two system clocks, low then high. An 8-step instruction-only command ends 16 clocks after its start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 32 | Register write data |
| tx_data | input | 8 | Head byte of the write FIFO |
| tx_valid | input | 1 | Write FIFO holds a byte |
| tx_pop | output | 1 | Takes the head byte of the write FIFO |
| rx_full | input | 1 | Read FIFO cannot accept a byte |
| rx_data | output | 8 | Received byte |
| rx_push | output | 1 | rx_data is valid this cycle |
| io_in | input | 4 | Flash data lines, input side |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Flash data lines, output side |
| io_oe | output | 4 | Per-line output enable |
| busy | output | 1 | Transaction in progress |
| done_flag | output | 1 | Sticky transfer-complete flag |
| err_flag | output | 1 | Sticky transfer-error flag |
| fifo_thr | output | 1 | Sequencer waits for a write byte, or a read byte is delivered |
| abort_bit | output | 1 | Abort in progress, self-clearing |

## Verification
Busy, cs_n, err_flag and abort_bit respond on the same edge that takes the register write, so the bench checks them at the falling edge that follows the write. done_flag and the final cs_n rise come 2·N clocks after the start edge for N serial steps. The bench checks that exact count for an instruction-only command, both one sample before and at the expected clock. The line levels are recorded at every falling clock edge while sck is high. io_in is changed only in that high half, so the sequencer's next rising sample always sees a settled value. The expected values are rebuilt from those records and compared after the transaction ends. Stalls are checked by holding the FIFO condition for a fixed number of clocks and confirming that no serial clock edge is recorded.

// File: rtl/qspi_seq.sv
module qspi_seq #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [31:0]      wr_data,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_pop,
  input  logic             rx_full,
  output logic [7:0]       rx_data,
  output logic             rx_push,
  input  logic [3:0]       io_in,
  output logic             sck,
  output logic             cs_n,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  output logic             busy,
  output logic             done_flag,
  output logic             err_flag,
  output logic             fifo_thr,
  output logic             abort_bit
);
  localparam int CW = 24;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_DUMMY, S_BWAIT, S_DATA} st_t;

  st_t             st;
  logic            ph;
  logic [CW-1:0]   cfg;
  logic [31:0]     addr;
  logic [LEN_W-1:0] len, left;
  logic [5:0]      cnt;
  logic [31:0]     sh;
  logic [7:0]      rsh;

  function automatic logic [2:0] lanes(logic [1:0] m);
    return (m == 2'd3) ? 3'd4 : (m == 2'd2) ? 3'd2 : 3'd1;
  endfunction

  function automatic st_t after_dummy(logic [CW-1:0] c);
    return (c[21:20] != 2'd0) ? S_BWAIT : S_IDLE;
  endfunction

  function automatic st_t after_addr(logic [CW-1:0] c);
    return (c[19:14] != 6'd0) ? S_DUMMY : after_dummy(c);
  endfunction

  function automatic st_t after_cmd(logic [CW-1:0] c);
    return (c[11:10] != 2'd0) ? S_ADDR : after_addr(c);
  endfunction

  function automatic st_t first_of(logic [CW-1:0] c);
    return (c[9:8] != 2'd0) ? S_CMD : after_cmd(c);
  endfunction

  function automatic logic [37:0] load(st_t ns, logic [CW-1:0] c, logic [31:0] a);
    logic [5:0]  n;
    logic [31:0] s;
    int          asz;
    n   = 6'd0;
    s   = 32'd0;
    asz = int'(c[13:12]);
    case (ns)
      S_CMD: begin
        s = {c[7:0], 24'h0};
        n = 6'(8 / int'(lanes(c[9:8])));
      end
      S_ADDR: begin
        s = a << (8 * (3 - asz));
        n = 6'((8 * (asz + 1)) / int'(lanes(c[11:10])));
      end
      S_DUMMY: n = c[19:14];
      default: ;
    endcase
    return {n, s};
  endfunction

  logic       is_rd, active, drive, wr_abort, wr_clr, go;
  logic [1:0] cur_mode;
  logic [2:0] lw;
  logic [3:0] oe_pat;
  logic [7:0] rnext;
  logic [CW-1:0] go_cfg;
  logic [31:0]   go_addr;
  st_t        first_st, end_ns;

  assign is_rd    = cfg[23:22] == 2'd1;
  assign active   = st inside {S_CMD, S_ADDR, S_DUMMY, S_DATA};
  assign drive    = (st == S_CMD) || (st == S_ADDR) || (st == S_DATA && !is_rd);
  assign wr_abort = wr_en && wr_sel == 3'd0 && wr_data[0];
  assign wr_clr   = wr_en && wr_sel == 3'd4;

  always_comb begin
    case (st)
      S_CMD:          cur_mode = cfg[9:8];
      S_ADDR:         cur_mode = cfg[11:10];
      S_BWAIT, S_DATA: cur_mode = cfg[21:20];
      default:        cur_mode = 2'd1;
    endcase
  end

  assign lw     = lanes(cur_mode);
  assign oe_pat = (lw == 3'd4) ? 4'hF : (lw == 3'd2) ? 4'h3 : 4'h1;
  assign io_oe  = drive ? oe_pat : 4'h0;
  assign io_out = !drive ? 4'h0 :
                  (lw == 3'd4) ? sh[31:28] :
                  (lw == 3'd2) ? {2'b00, sh[31:30]} : {3'b000, sh[31]};
  assign rnext  = (lw == 3'd4) ? {rsh[3:0], io_in} :
                  (lw == 3'd2) ? {rsh[5:0], io_in[1:0]} : {rsh[6:0], io_in[1]};

  assign sck      = active && ph;
  assign cs_n     = st == S_IDLE;
  assign busy     = st != S_IDLE;
  assign tx_pop   = st == S_BWAIT && !is_rd && tx_valid;
  assign fifo_thr = (st == S_BWAIT && !is_rd && !tx_valid) || rx_push;

  assign go       = wr_en && ((wr_sel == 3'd1 && wr_data[11:10] == 2'd0) ||
                              (wr_sel == 3'd2 && cfg[11:10] != 2'd0));
  assign go_cfg   = (wr_sel == 3'd1) ? wr_data[CW-1:0] : cfg;
  assign go_addr  = (wr_sel == 3'd2) ? wr_data : addr;
  assign first_st = first_of(go_cfg);

  always_comb begin
    case (st)
      S_CMD:   end_ns = after_cmd(cfg);
      S_ADDR:  end_ns = after_addr(cfg);
      S_DUMMY: end_ns = after_dummy(cfg);
      S_DATA:  end_ns = (left == '0) ? S_IDLE : S_BWAIT;
      default: end_ns = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ph        <= 1'b0;
      cfg       <= '0;
      addr      <= '0;
      len       <= '0;
      left      <= '0;
      cnt       <= '0;
      sh        <= '0;
      rsh       <= '0;
      rx_data   <= '0;
      rx_push   <= 1'b0;
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
      abort_bit <= 1'b0;
    end else begin
      rx_push   <= 1'b0;
      abort_bit <= wr_abort;
      if (wr_clr) begin
        if (wr_data[0]) done_flag <= 1'b0;
        if (wr_data[1]) err_flag  <= 1'b0;
      end
      if (wr_abort) begin
        st <= S_IDLE;
        ph <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (wr_en) begin
            case (wr_sel)
              3'd1:    cfg  <= wr_data[CW-1:0];
              3'd2:    addr <= wr_data;
              3'd3:    len  <= wr_data[LEN_W-1:0];
              default: ;
            endcase
            if (go) begin
              if (go_cfg[23:22] > 2'd1) begin
                err_flag <= 1'b1;
              end else begin
                st        <= first_st;
                {cnt, sh} <= load(first_st, go_cfg, go_addr);
                ph        <= 1'b0;
                left      <= len;
                if (first_st == S_IDLE) done_flag <= 1'b1;
              end
            end
          end
          S_BWAIT: begin
            if (is_rd) begin
              if (!rx_full) begin
                cnt <= 6'(8 / int'(lw));
                st  <= S_DATA;
              end
            end else if (tx_valid) begin
              sh  <= {tx_data, 24'h0};
              cnt <= 6'(8 / int'(lw));
              st  <= S_DATA;
            end
          end
          default: begin
            if (!ph) begin
              ph <= 1'b1;
              if (st == S_DATA && is_rd) begin
                rsh <= rnext;
                if (cnt == 6'd1) begin
                  rx_data <= rnext;
                  rx_push <= 1'b1;
                end
              end
            end else begin
              ph <= 1'b0;
              if (cnt > 6'd1) begin
                cnt <= cnt - 6'd1;
                sh  <= sh << lw;
              end else begin
                st        <= end_ns;
                {cnt, sh} <= load(end_ns, cfg, addr);
                if (st == S_DATA && left != '0) left <= left - 1'b1;
                if (end_ns == S_IDLE) done_flag <= 1'b1;
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/qspi_seq_chk.sv
module qspi_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic        busy,
  input logic        done_flag,
  input logic        err_flag,
  input logic        fifo_thr,
  input logic        abort_bit,
  input logic        tx_pop,
  input logic        rx_push,
  input logic        sck,
  input logic        cs_n,
  input logic [3:0]  io_oe
);
  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0 && wr_data[0]) |=> (!busy && cs_n && abort_bit));

  // R11
  abort_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_bit && !(wr_en && wr_sel == 3'd0 && wr_data[0])) |=> !abort_bit);

  // R9
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> cs_n);

  // R10
  err_no_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> cs_n);

  // R4
  oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'h0 || io_oe == 4'h1 || io_oe == 4'h3 || io_oe == 4'hF) && (busy || io_oe == 4'h0));

  // R7
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_thr && !rx_push) |-> !sck);

  // R7
  pop_then_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> (busy && !sck && io_oe != 4'h0));

  // R8
  push_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> busy);

  // R12
  sck_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> (!cs_n && $past(!sck)));
endmodule

bind qspi_seq qspi_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .busy(busy), .done_flag(done_flag), .err_flag(err_flag), .fifo_thr(fifo_thr),
  .abort_bit(abort_bit), .tx_pop(tx_pop), .rx_push(rx_push), .sck(sck),
  .cs_n(cs_n), .io_oe(io_oe)
);

// File: tb/tb_qspi_seq.sv
module tb_qspi_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [31:0] wr_data;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_pop, rx_full, rx_push;
  logic [7:0]  rx_data;
  logic [3:0]  io_in, io_out, io_oe;
  logic        sck, cs_n, busy, done_flag, err_flag, fifo_thr, abort_bit;

  always #5 clk = ~clk;

  qspi_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_pop(tx_pop), .rx_full(rx_full),
    .rx_data(rx_data), .rx_push(rx_push), .io_in(io_in), .sck(sck), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .busy(busy), .done_flag(done_flag),
    .err_flag(err_flag), .fifo_thr(fifo_thr), .abort_bit(abort_bit)
  );

  int n_chk = 0, n_fail = 0;
  logic [3:0] m_out [256];
  logic [3:0] m_oe  [256];
  int m_n = 0, rd_step = 0, rx_n = 0, tx_cnt = 0, tx_n = 0;
  logic [7:0] rx_cap [16];
  logic [7:0] tx_q [16];

  function automatic logic [3:0] fpat(int k);
    return 4'((k * 7 + 5) % 16);
  endfunction

  assign io_in    = fpat(rd_step);
  assign tx_valid = tx_n < tx_cnt;
  assign tx_data  = tx_q[tx_n % 16];

  always @(negedge clk) begin
    if (sck) begin
      if (m_n < 256) begin
        m_out[m_n] = io_out;
        m_oe[m_n]  = io_oe;
      end
      m_n = m_n + 1;
      if (io_oe == 4'h0) rd_step = rd_step + 1;
    end
    if (rx_push) begin
      if (rx_n < 16) rx_cap[rx_n] = rx_data;
      rx_n = rx_n + 1;
    end
  end

  always @(posedge clk) if (tx_pop) tx_n <= tx_n + 1;

  function automatic logic [31:0] mk(logic [7:0] o, logic [1:0] im, logic [1:0] am,
                                     logic [1:0] asz, logic [5:0] dc, logic [1:0] dm,
                                     logic [1:0] fm);
    return {8'h00, fm, dm, dc, asz, am, im, o};
  endfunction

  function automatic logic [31:0] gather(int base, int steps, int w);
    logic [31:0] r = 0;
    for (int i = 0; i < steps; i++) begin
      logic [3:0] v = m_out[(base + i) % 256];
      if (w == 4)      r = {r[27:0], v};
      else if (w == 2) r = {r[29:0], v[1:0]};
      else             r = {r[30:0], v[0]};
    end
    return r;
  endfunction

  function automatic int oe_bad(int base, int steps, logic [3:0] exp);
    int bad = 0;
    for (int i = 0; i < steps; i++) if (m_oe[(base + i) % 256] != exp) bad++;
    return bad;
  endfunction

  function automatic logic [7:0] exp_rd(int k0, int w);
    logic [7:0] r = 0;
    for (int i = 0; i < 8 / w; i++) begin
      logic [3:0] v = fpat(k0 + i);
      if (w == 4)      r = {r[3:0], v};
      else if (w == 2) r = {r[5:0], v[1:0]};
      else             r = {r[6:0], v[1]};
    end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 cs_n", cs_n, 1);
    check("R1 sck", sck, 0);
    check("R1 io_oe", io_oe, 0);
    check("R1 status", {busy, done_flag, err_flag, fifo_thr, abort_bit}, 0);
  endtask

  task automatic t_cmd_only();
    int b = m_n;
    wr(3'd1, mk(8'h06, 2'd1, 2'd0, 2'd0, 6'd0, 2'd0, 2'd0));
    check("R2 start on command write", busy, 1);
    repeat (15) @(negedge clk);
    check("R12 still busy at clock 15", busy, 1);
    @(negedge clk);
    check("R12 ends at clock 16", busy, 0);
    check("R9 done set", done_flag, 1);
    check("R3 instruction steps", m_n - b, 8);
    check("R4 single opcode MSB first", gather(b, 8, 1), 32'h06);
    check("R4 single oe", oe_bad(b, 8, 4'h1), 0);
    wr(3'd4, 32'h1);
    check("R9 done cleared", done_flag, 0);
  endtask

  task automatic t_quad_write();
    int b, p0;
    tx_q[tx_cnt % 16] = 8'hA5; tx_q[(tx_cnt + 1) % 16] = 8'h3C; tx_cnt += 2;
    wr(3'd3, 32'd1);
    wr(3'd1, mk(8'h32, 2'd1, 2'd3, 2'd2, 6'd0, 2'd3, 2'd0));
    check("R2 no start on command write with address", busy, 0);
    b = m_n; p0 = tx_n;
    wr(3'd2, 32'h0012_3456);
    check("R2 start on address write", busy, 1);
    wait_idle();
    check("R5 quad write step count", m_n - b, 18);
    check("R4 opcode", gather(b, 8, 1), 32'h32);
    check("R5 three address bytes quad", gather(b + 8, 6, 4), 32'h123456);
    check("R4 quad data nibbles", gather(b + 14, 4, 4), 32'hA53C);
    check("R4 quad oe", oe_bad(b + 8, 10, 4'hF), 0);
    check("R7 two pops", tx_n - p0, 2);
    wr(3'd4, 32'h3);
  endtask

  task automatic t_dual_read();
    int b, k0, r0;
    wr(3'd3, 32'd1);
    wr(3'd1, mk(8'h3B, 2'd1, 2'd2, 2'd0, 6'd4, 2'd2, 2'd1));
    b = m_n; k0 = rd_step; r0 = rx_n;
    wr(3'd2, 32'h80);
    wait_idle();
    check("R6 step count with four dummy clocks", m_n - b, 24);
    check("R4 dual address byte", gather(b + 8, 4, 2), 32'h80);
    check("R6 released lines", oe_bad(b + 12, 12, 4'h0), 0);
    check("R8 two bytes pushed", rx_n - r0, 2);
    check("R8 dual byte 0", rx_cap[r0 % 16], exp_rd(k0 + 4, 2));
    check("R8 dual byte 1", rx_cap[(r0 + 1) % 16], exp_rd(k0 + 8, 2));
    wr(3'd4, 32'h3);
  endtask

  task automatic t_single_read_stall();
    int b, k0, r0;
    rx_full = 1'b1;
    wr(3'd3, 32'd0);
    b = m_n; k0 = rd_step; r0 = rx_n;
    wr(3'd1, mk(8'h00, 2'd0, 2'd0, 2'd0, 6'd0, 2'd1, 2'd1));
    check("R3 data-only start", busy, 1);
    repeat (10) @(negedge clk);
    check("R8 stalled no clocks", m_n - b, 0);
    check("R8 sck low in stall", sck, 0);
    rx_full = 1'b0;
    wait_idle();
    check("R3 only data steps", m_n - b, 8);
    check("R4 single read on io1", rx_cap[r0 % 16], exp_rd(k0, 1));
    wr(3'd4, 32'h3);
  endtask

  task automatic t_write_stall_ignore();
    int b, p0;
    wr(3'd3, 32'd2);
    b = m_n; p0 = tx_n;
    wr(3'd1, mk(8'h02, 2'd1, 2'd0, 2'd0, 6'd0, 2'd1, 2'd0));
    repeat (20) @(negedge clk);
    check("R7 fifo_thr while empty", fifo_thr, 1);
    check("R7 sck low while empty", sck, 0);
    wr(3'd1, mk(8'h00, 2'd0, 2'd0, 2'd0, 6'd0, 2'd0, 2'd0));
    wr(3'd3, 32'd0);
    check("R2 busy kept", busy, 1);
    tx_q[tx_cnt % 16] = 8'h81; tx_q[(tx_cnt + 1) % 16] = 8'h7E;
    tx_q[(tx_cnt + 2) % 16] = 8'hC3; tx_cnt += 3;
    wait_idle();
    check("R2 writes while busy ignored", m_n - b, 32);
    check("R7 single write bytes", gather(b + 8, 24, 1), 32'h817EC3);
    check("R7 three pops", tx_n - p0, 3);
    wr(3'd4, 32'h3);
  endtask

  task automatic t_error();
    wr(3'd1, mk(8'h00, 2'd1, 2'd0, 2'd0, 6'd0, 2'd0, 2'd3));
    check("R10 err on code 3", err_flag, 1);
    check("R10 no transaction", {busy, cs_n}, 2'b01);
    wr(3'd4, 32'h2);
    check("R10 err cleared", err_flag, 0);
    wr(3'd1, mk(8'h00, 2'd1, 2'd0, 2'd0, 6'd0, 2'd0, 2'd2));
    check("R10 err on code 2", {err_flag, busy}, 2'b10);
    wr(3'd4, 32'h2);
  endtask

  task automatic t_abort();
    int b;
    wr(3'd1, mk(8'hAB, 2'd1, 2'd0, 2'd0, 6'd0, 2'd1, 2'd0));
    repeat (5) @(negedge clk);
    check("R11 busy before abort", busy, 1);
    wr(3'd0, 32'h1);
    check("R11 idle after abort", {busy, cs_n, sck}, 3'b010);
    check("R11 abort bit high", abort_bit, 1);
    check("R11 done untouched", done_flag, 0);
    @(negedge clk);
    check("R11 abort bit cleared", abort_bit, 0);
    b = m_n;
    wr(3'd1, mk(8'h5A, 2'd1, 2'd0, 2'd0, 6'd0, 2'd0, 2'd0));
    wait_idle();
    check("R11 next command runs", gather(b, 8, 1), 32'h5A);
    wr(3'd4, 32'h3);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 3'd0; wr_data = 32'd0; rx_full = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_cmd_only();
    t_quad_write();
    t_dual_read();
    t_single_read_stall();
    t_write_stall_ignore();
    t_error();
    t_abort();
    finish_up();
  end
endmodule